// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is a register-mapped interval timer. Its counter is either 16 or 32 bits wide, set by a parameter. While enabled, the counter steps down by one on each pulse of the tick strobe that the control register selects. Two strobes arrive from outside the block. The fast one runs at about 508.469 kHz and the slow one at a lower rate.

When the count is already zero and another selected tick arrives, the counter underflows and a level interrupt goes high. What the counter does next depends on the mode. In periodic mode it takes the programmed start value again. In free-running mode it wraps to all ones.

Software reaches the block over a simple 32-bit register bus that has single-cycle writes and combinational reads. The bus has four word registers:

- a start value at offset 0x00,
- the live count at 0x04,
- control at 0x08,
- an acknowledge location at 0x0C.

Any write to the acknowledge location lowers the interrupt.

Top module: `reload_timer`

## Requirements
- R1: After reset the start value, the count and the control fields all read as zero, and `irq` is low.
- R2: When enable (control bit 7) is 1, each selected tick lowers the count by one. A selected tick that arrives while the count is zero is an underflow, and `irq` is high after that clock edge.
- R3: In periodic mode (control bit 6 = 1), an underflow puts the start value back into the counter.
- R4: Control bit 3 selects the tick: 1 selects `tick_fast` and 0 selects `tick_slow`. The strobe that is not selected has no effect on the count.
- R5: In free-running mode (control bit 6 = 0), an underflow wraps the count to all ones of the counter width.
- R6: A write of any data to offset 0x0C lowers `irq`. A read of 0x0C returns zero.
- R7: A control write with bit 7 = 0 stops counting and lowers `irq`.
- R8: A write to offset 0x00 sets the start value and the count at the same edge, truncated to the counter width. A tick in a cycle that writes the start value or control is ignored.
- R9: Offset 0x04 returns the live count, zero-extended to 32 bits. A write to 0x04 changes nothing.
- R10: A read of control returns only bits 7, 6 and 3 as written. All other bits read as zero.
- R11: If an underflow happens in the same cycle as a write to 0x0C, `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (zero when no read) |
| tick_fast | input | 1 | Fast tick-enable strobe |
| tick_slow | input | 1 | Slow tick-enable strobe |
| irq | output | 1 | Level underflow interrupt |

## Verification
The properties assume the following about the inputs:

- each strobe is a single-cycle enable sampled at the clock edge,
- a bus access lasts exactly one cycle,
- no read gives a side effect.

Beyond that, they let ticks and register writes land in any cycle relative to one another, including the case where an underflow coincides with a write.

The random stimulus drives both strobes every cycle with even odds. It writes in about one cycle of eight, and mostly uses small start values so that underflows, reloads and wraps happen often. Directed cases pin down the same-cycle collisions between a tick and a write.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
   localparam int BUS_W        = 32;
   localparam int OFF_START    = 'h0;
   localparam int OFF_COUNT    = 'h4;
   localparam int OFF_CTRL     = 'h8;
   localparam int OFF_ACK      = 'hC;
   localparam int CTRL_EN_POS   = 7;
   localparam int CTRL_PER_POS  = 6;
   localparam int CTRL_FAST_POS = 3;

   typedef struct packed {
      logic en;
      logic periodic;
      logic fast;
   } tmr_ctrl_t;
endpackage

// File: rtl/reload_timer_regs.sv
module reload_timer_regs
   import reload_timer_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [BUS_W-1:0]    bus_wdata,
   input  logic [CNT_W-1:0]    cnt,
   output logic [CNT_W-1:0]    start_q,
   output tmr_ctrl_t           ctrl_q,
   output logic                wr_start,
   output logic                wr_ctrl,
   output logic                wr_ack,
   output logic [BUS_W-1:0]    bus_rdata
);
   localparam int PAD_W = BUS_W - CNT_W;

   logic            rd;
   logic [BUS_W-1:0] start_ext, cnt_ext, ctrl_ext;
   logic            unused_wdata;

   assign rd       = bus_sel & ~bus_wr;
   assign wr_start = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFF_START));
   assign wr_ctrl  = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFF_CTRL));
   assign wr_ack   = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFF_ACK));
   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         ctrl_q  <= '0;
      end else begin
         if (wr_start) start_q <= bus_wdata[CNT_W-1:0];
         if (wr_ctrl) begin
            ctrl_q.en       <= bus_wdata[CTRL_EN_POS];
            ctrl_q.periodic <= bus_wdata[CTRL_PER_POS];
            ctrl_q.fast     <= bus_wdata[CTRL_FAST_POS];
         end
      end
   end

   generate
      if (PAD_W == 0) begin : g_full
         assign start_ext = start_q;
         assign cnt_ext   = cnt;
      end else begin : g_pad
         assign start_ext = {{PAD_W{1'b0}}, start_q};
         assign cnt_ext   = {{PAD_W{1'b0}}, cnt};
      end
   endgenerate

   always_comb begin
      ctrl_ext = '0;
      ctrl_ext[CTRL_EN_POS]   = ctrl_q.en;
      ctrl_ext[CTRL_PER_POS]  = ctrl_q.periodic;
      ctrl_ext[CTRL_FAST_POS] = ctrl_q.fast;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         case (bus_addr)
            ADDR_W'(OFF_START): bus_rdata = start_ext;
            ADDR_W'(OFF_COUNT): bus_rdata = cnt_ext;
            ADDR_W'(OFF_CTRL):  bus_rdata = ctrl_ext;
            default:            bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/reload_timer_count.sv
module reload_timer_count
   import reload_timer_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tmr_ctrl_t        ctrl_q,
   input  logic             tick_fast,
   input  logic             tick_slow,
   input  logic             wr_start,
   input  logic             wr_ctrl,
   input  logic [CNT_W-1:0] start_new,
   input  logic [CNT_W-1:0] start_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             uflow
);
   logic             tick_sel, step, at_zero;
   logic [CNT_W-1:0] after_uflow;

   assign tick_sel = ctrl_q.fast ? tick_fast : tick_slow;
   assign step     = ctrl_q.en & tick_sel & ~wr_start & ~wr_ctrl;
   assign at_zero  = (cnt_q == '0);
   assign uflow    = step & at_zero;

   assign after_uflow = ctrl_q.periodic ? start_q : {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (wr_start) cnt_q <= start_new;
      else if (uflow)    cnt_q <= after_uflow;
      else if (step)     cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/reload_timer_irq.sv
module reload_timer_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic uflow,
   input  logic wr_ack,
   input  logic wr_ctrl,
   input  logic new_en,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)                          irq <= 1'b0;
      else if (uflow)                      irq <= 1'b1;
      else if (wr_ack || (wr_ctrl && !new_en)) irq <= 1'b0;
   end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
   import reload_timer_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              tick_fast,
   input  logic              tick_slow,
   output logic              irq
);
   generate
      if (!(CNT_W == 16 || CNT_W == 32)) begin : g_bad_width
         $error("reload_timer: CNT_W must be 16 or 32");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("reload_timer: ADDR_W must be at least 4");
      end
   endgenerate

   logic [CNT_W-1:0] start_q, cnt_q;
   tmr_ctrl_t        ctrl_q;
   logic             wr_start, wr_ctrl, wr_ack, uflow;

   reload_timer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt_q),
      .start_q(start_q), .ctrl_q(ctrl_q), .wr_start(wr_start),
      .wr_ctrl(wr_ctrl), .wr_ack(wr_ack), .bus_rdata(bus_rdata)
   );

   reload_timer_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .tick_fast(tick_fast),
      .tick_slow(tick_slow), .wr_start(wr_start), .wr_ctrl(wr_ctrl),
      .start_new(bus_wdata[CNT_W-1:0]), .start_q(start_q),
      .cnt_q(cnt_q), .uflow(uflow)
   );

   reload_timer_irq u_irq (
      .clk(clk), .rst_n(rst_n), .uflow(uflow), .wr_ack(wr_ack),
      .wr_ctrl(wr_ctrl), .new_en(bus_wdata[CTRL_EN_POS]), .irq(irq)
   );
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq,
   input logic             uflow,
   input logic             wr_start,
   input logic             wr_ctrl,
   input logic             wr_ack,
   input logic [31:0]      bus_wdata,
   input logic             en,
   input logic             periodic,
   input logic [CNT_W-1:0] start_q,
   input logic [CNT_W-1:0] cnt_q
);
   // R2
   uflow_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uflow |=> irq);
   // R3
   periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow && periodic) |=> (cnt_q == $past(start_q)));
   // R5
   freerun_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow && !periodic) |=> (cnt_q == {CNT_W{1'b1}}));
   // R6
   ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack && !uflow) |=> !irq);
   // R7
   disable_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !bus_wdata[7]) |=> (!irq && !en));
   // R7
   idle_holds_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !wr_start) |=> $stable(cnt_q));
   // R8
   start_write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> (cnt_q == $past(bus_wdata[CNT_W-1:0])));
   // R2
   no_irq_rise_without_uflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !uflow) |=> !irq);
endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .uflow(uflow),
   .wr_start(wr_start), .wr_ctrl(wr_ctrl), .wr_ack(wr_ack),
   .bus_wdata(bus_wdata), .en(ctrl_q.en), .periodic(ctrl_q.periodic),
   .start_q(start_q), .cnt_q(cnt_q)
);

// File: tb/reload_timer_bench.sv
module reload_timer_bench;
   localparam int CW = 16;
   localparam int AW = 4;
   localparam logic [31:0] MASK = 32'((64'd1 << CW) - 64'd1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          tick_fast = 1'b0, tick_slow = 1'b0;
   logic          irq;

   int checks = 0;
   int failures = 0;

   logic [31:0] m_start = 0, m_cnt = 0;
   logic        m_en = 0, m_per = 0, m_fast = 0, m_irq = 0;

   always #4 clk = ~clk;

   reload_timer #(.CNT_W(CW), .ADDR_W(AW)) u_reload_timer (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq)
   );

   function automatic logic [31:0] ctrl_image(logic en, logic per, logic fast);
      return {24'd0, en, per, 2'b00, fast, 3'b000};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Called at a falling edge; applies inputs over one rising edge and
   // advances the reference model with the same inputs.
   task automatic cycle(logic sel, logic wr, logic [3:0] addr,
                        logic [31:0] data, logic tf, logic ts);
      logic wl, wc, wa, tk, stp, uf;
      bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = data;
      tick_fast = tf; tick_slow = ts;
      wl  = sel && wr && addr == 4'h0;
      wc  = sel && wr && addr == 4'h8;
      wa  = sel && wr && addr == 4'hC;
      tk  = m_fast ? tf : ts;
      stp = m_en && tk && !wl && !wc;
      uf  = stp && m_cnt == 0;
      @(posedge clk);
      if (uf) m_irq = 1;
      else if (wa || (wc && !data[7])) m_irq = 0;
      if (wl) begin
         m_cnt = data & MASK; m_start = data & MASK;
      end else if (uf) m_cnt = m_per ? m_start : MASK;
      else if (stp) m_cnt = m_cnt - 1;
      if (wc) begin
         m_en = data[7]; m_per = data[6]; m_fast = data[3];
      end
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; tick_fast = 0; tick_slow = 0;
   endtask

   task automatic rd(logic [3:0] addr, output logic [31:0] val);
      bus_sel = 1; bus_wr = 0; bus_addr = addr;
      #1 val = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic wr(logic [3:0] addr, logic [31:0] data, logic tf, logic ts);
      cycle(1'b1, 1'b1, addr, data, tf, ts);
   endtask

   task automatic idle(logic tf, logic ts);
      cycle(1'b0, 1'b0, 4'h0, 32'h0, tf, ts);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      rd(4'h0, v); chk("R1 start", v, 0);
      rd(4'h4, v); chk("R1 count", v, 0);
      rd(4'h8, v); chk("R1 ctrl", v, 0);
      chk("R1 irq", irq, 0);

      // R8 start write truncates and loads count
      wr(4'h0, 32'h0001_0005, 1, 1);
      rd(4'h0, v); chk("R8 start truncated", v, 5);
      rd(4'h4, v); chk("R8 count loaded", v, 5);
      wr(4'h8, 32'hC8, 1, 1);
      rd(4'h4, v); chk("R8 tick ignored in ctrl write", v, 5);
      rd(4'h8, v); chk("R10 ctrl readback", v, 32'hC8);

      // R2 five fast ticks reach zero, no irq yet
      repeat (5) idle(1, 0);
      rd(4'h4, v); chk("R2 count at zero", v, 0);
      chk("R2 no irq before underflow", irq, 0);
      // R4 slow strobe ignored with fast selected
      repeat (3) idle(0, 1);
      rd(4'h4, v); chk("R4 slow ignored", v, 0);
      chk("R4 no irq from slow", irq, 0);
      // R2 R3 underflow then reload
      idle(1, 0);
      chk("R2 irq on underflow", irq, 1);
      rd(4'h4, v); chk("R3 periodic reload", v, 5);

      // R6 ack
      wr(4'hC, 32'h0, 0, 0);
      chk("R6 ack drops irq", irq, 0);
      rd(4'hC, v); chk("R6 ack reads zero", v, 0);

      // R9 count write ignored
      wr(4'h4, 32'h1234, 0, 0);
      rd(4'h4, v); chk("R9 count write ignored", v, 5);

      // R5 free-running wrap on slow tick
      wr(4'h0, 32'h2, 0, 0);
      rd(4'h4, v); chk("R8 immediate load", v, 2);
      wr(4'h8, 32'h80, 0, 0);
      repeat (3) idle(0, 1);
      rd(4'h4, v); chk("R5 wrap to all ones", v, 32'h0000_FFFF);
      chk("R5 irq on wrap", irq, 1);
      chk("R9 zero extension", v[31:16], 0);

      // R11 underflow beats ack in the same cycle
      wr(4'hC, 32'hDEAD_BEEF, 0, 0);
      chk("R6 ack any data", irq, 0);
      wr(4'h0, 32'h0, 0, 0);
      wr(4'hC, 32'h1, 0, 1);
      chk("R11 irq kept on collision", irq, 1);
      rd(4'h4, v); chk("R11 count wrapped", v, 32'hFFFF);

      // R7 disable clears irq and freezes count
      wr(4'h8, 32'h0, 0, 0);
      chk("R7 disable drops irq", irq, 0);
      repeat (4) idle(1, 1);
      rd(4'h4, v); chk("R7 count frozen", v, 32'hFFFF);

      // R10 only defined control bits stored
      wr(4'h8, 32'hFFFF_FF37, 0, 0);
      rd(4'h8, v); chk("R10 reserved bits zero", v, 0);
      wr(4'h8, 32'hFFFF_FFFF, 0, 0);
      rd(4'h8, v); chk("R10 all bits", v, 32'hC8);

      // random phase against the reference model
      for (int i = 0; i < 4000; i++) begin
         logic tf, ts;
         tf = $urandom_range(0, 1);
         ts = $urandom_range(0, 1);
         if ($urandom_range(0, 7) == 0) begin
            logic [3:0]  a;
            logic [31:0] d;
            a = 4'($urandom_range(0, 3) * 4);
            d = $urandom;
            if (a == 4'h0 && $urandom_range(0, 3) != 0) d = $urandom_range(0, 24);
            if (a == 4'h8) begin
               d = d & 32'hFFFF_FF7F;
               if ($urandom_range(0, 3) != 0) d = d | 32'h80;
            end
            wr(a, d, tf, ts);
         end else begin
            idle(tf, ts);
         end
         chk("R2 R3 R5 random irq", irq, m_irq);
         rd(4'h4, v); chk("R2 R3 R5 random count", v, m_cnt);
         if (i % 64 == 0) begin
            rd(4'h8, v); chk("R10 random ctrl", v, ctrl_image(m_en, m_per, m_fast));
            rd(4'h0, v); chk("R8 random start", v, m_start);
         end
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule